// File: doc/BRIEF.md
# Mode-Steered Shadow Integer Register File

This block is a 64-bit integer register file with two combinational read ports and one synchronous write port. Besides the 32 normal registers it holds a small bank of shadow registers used by privileged code. Each access carries its own 5-bit register index and its own mode bit. When the mode bit of an access is set and its index is one of the steered indices, the access goes to a shadow register instead of the normal one. The register contents never move when the processor changes mode. The mode is a property of each instruction: it is the low bit of that instruction's fetch address, carried alongside the instruction word.

The steered indices are 8 through 14 and 25. In privileged mode they map in ascending order onto physical registers 32 through 39. For every access the block reports the physical register number as a dependency tag. A scheduler can use that tag to track hazards without knowing the steering rule. Index 31 is a hard zero in both modes. A write is committed on the rising clock edge. A read in the same cycle still sees the earlier contents.

Top module: `shreg_rf_top`

## Requirements
- R1: The file holds 40 physical 64-bit registers. Tags 0 to 31 denote the normal registers and tags 32 to 39 denote the shadow registers. Every port reports its physical tag, which is always below 40.
- R2: With the mode bit of an access at 0, index i reaches normal register i and the tag equals i, for all 32 indices.
- R3: With the mode bit at 1, indices 8..14 reach shadow tags 32..38 (index plus 24), and index 25 reaches tag 39. Every other index reaches its normal register, with the tag equal to the index.
- R4: Read port A, read port B and the write port steer independently, each by its own mode bit. Two ports given the same index and mode return the same tag and the same data.
- R5: Index 31 reads as zero in both modes. A write to index 31 changes no register.
- R6: When wr_en is high at a rising clock edge, the addressed physical register takes wc_data. The new value is visible on the read ports from the next cycle on.
- R7: A read of the register that is being written in the same cycle returns the value it held before that write. There is no bypass.
- R8: An asynchronous active-low reset clears all 40 registers to zero.
- R9: With wr_en low, no register changes, whatever the write index, mode and data are.
- R10: Changing the mode moves no contents. A shadow register and the normal register with the same index keep separate values across any sequence of accesses in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ra_idx | input | 5 | Read port A register index |
| ra_mode | input | 1 | Read port A privileged-mode bit |
| ra_data | output | 64 | Read port A data (combinational) |
| ra_tag | output | 6 | Read port A physical tag |
| rb_idx | input | 5 | Read port B register index |
| rb_mode | input | 1 | Read port B privileged-mode bit |
| rb_data | output | 64 | Read port B data (combinational) |
| rb_tag | output | 6 | Read port B physical tag |
| wr_en | input | 1 | Write enable |
| wc_idx | input | 5 | Write port register index |
| wc_mode | input | 1 | Write port privileged-mode bit |
| wc_data | input | 64 | Write data |
| wc_tag | output | 6 | Write port physical tag |

## Verification
The bench builds the block with its default parameters: 64-bit data, 32 normal registers, 8 shadow registers, and the steering mask that covers indices 8..14 and 25. These are the only values under which the fixed mapping to tags 32..39 holds. With them, every steered index, every index that is never steered, and the zero register can each be reached from every port in both modes. A behavioural model keeps the normal and shadow contents in two separate arrays. It is compared with all five outputs on every cycle, including cycles where the write and a read hit the same register, and including a long run of random accesses with mixed modes.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    // Default configuration of the register file
    localparam int unsigned DEF_DATA_W      = 64;
    localparam int unsigned DEF_ARCH_REGS   = 32;
    localparam int unsigned DEF_SHADOW_REGS = 8;
    // Steered indices: 8..14 and 25
    localparam logic [31:0] DEF_REDIR_MASK  = 32'h0200_7F00;

    // Number of steered indices strictly below idx, i.e. the shadow slot
    function automatic int unsigned slot_below(input logic [31:0] mask,
                                               input int unsigned idx);
        int unsigned cnt;
        cnt = 0;
        for (int unsigned k = 0; k < 32; k++) begin
            if (k < idx && mask[k]) cnt++;
        end
        return cnt;
    endfunction

endpackage

// File: rtl/shreg_idx_xlate.sv
module shreg_idx_xlate #(
    parameter int unsigned ARCH_REGS  = 32,
    parameter int unsigned IDX_W      = 5,
    parameter int unsigned TAG_W      = 6,
    parameter logic [31:0] REDIR_MASK = 32'h0200_7F00
) (
    input  logic [IDX_W-1:0] arch_idx,
    input  logic             priv_mode,
    output logic [TAG_W-1:0] phys_tag
);
    import shreg_pkg::*;

    logic        steer;
    int unsigned slot;

    always_comb begin
        steer = priv_mode && REDIR_MASK[arch_idx];
        slot  = slot_below(REDIR_MASK, int'(arch_idx));
        if (steer) begin
            phys_tag = TAG_W'(ARCH_REGS + slot);
        end else begin
            phys_tag = TAG_W'(arch_idx);
        end
    end

endmodule

// File: rtl/shreg_bank.sv
module shreg_bank #(
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned NUM_PHYS = 40,
    parameter int unsigned TAG_W    = 6,
    parameter int unsigned ZERO_TAG = 31,
    parameter int unsigned NUM_RD   = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [TAG_W-1:0]               wtag,
    input  logic [DATA_W-1:0]              wdata,
    input  logic [NUM_RD-1:0][TAG_W-1:0]   rd_tag,
    output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data
);

    logic [NUM_PHYS-1:0][DATA_W-1:0] ent_flat;

    for (genvar k = 0; k < NUM_PHYS; k++) begin : g_ent
        if (k == ZERO_TAG) begin : g_zero
            assign ent_flat[k] = '0;
        end else begin : g_reg
            logic [DATA_W-1:0] ent_q;
            logic              hit;
            assign hit = we && (wtag == TAG_W'(k));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ent_q <= '0;
                end else if (hit) begin
                    ent_q <= wdata;
                end
            end
            assign ent_flat[k] = ent_q;

            // R9: an entry not addressed by an enabled write keeps its value
            assert_entry_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !(we && wtag == TAG_W'(k)) |=> $stable(ent_flat[k]));
            // R6: an addressed entry holds the written data one cycle later
            assert_entry_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (we && wtag == TAG_W'(k)) |=> ent_flat[k] == $past(wdata));
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        always_comb begin
            if (rd_tag[p] < TAG_W'(NUM_PHYS)) begin
                rd_data[p] = ent_flat[rd_tag[p]];
            end else begin
                rd_data[p] = '0;
            end
        end
    end

endmodule

// File: rtl/shreg_rf_top.sv
module shreg_rf_top #(
    parameter int unsigned DATA_W      = 64,
    parameter int unsigned ARCH_REGS   = 32,
    parameter int unsigned SHADOW_REGS = 8,
    parameter logic [31:0] REDIR_MASK  = 32'h0200_7F00,
    localparam int unsigned IDX_W      = $clog2(ARCH_REGS),
    localparam int unsigned NUM_PHYS   = ARCH_REGS + SHADOW_REGS,
    localparam int unsigned TAG_W      = $clog2(NUM_PHYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic              ra_mode,
    output logic [DATA_W-1:0] ra_data,
    output logic [TAG_W-1:0]  ra_tag,
    input  logic [IDX_W-1:0]  rb_idx,
    input  logic              rb_mode,
    output logic [DATA_W-1:0] rb_data,
    output logic [TAG_W-1:0]  rb_tag,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wc_idx,
    input  logic              wc_mode,
    input  logic [DATA_W-1:0] wc_data,
    output logic [TAG_W-1:0]  wc_tag
);

    localparam int unsigned NUM_PORTS = 3;
    localparam int unsigned NUM_RD    = 2;
    localparam int unsigned ZERO_IDX  = ARCH_REGS - 1;

    logic [NUM_PORTS-1:0][IDX_W-1:0] port_idx;
    logic [NUM_PORTS-1:0]            port_mode;
    logic [NUM_PORTS-1:0][TAG_W-1:0] port_tag;
    logic [NUM_RD-1:0][DATA_W-1:0]   rd_data;
    logic                            bank_we;

    assign port_idx  = {wc_idx, rb_idx, ra_idx};
    assign port_mode = {wc_mode, rb_mode, ra_mode};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_xlate
        shreg_idx_xlate #(
            .ARCH_REGS (ARCH_REGS),
            .IDX_W     (IDX_W),
            .TAG_W     (TAG_W),
            .REDIR_MASK(REDIR_MASK)
        ) u_xlate (
            .arch_idx (port_idx[p]),
            .priv_mode(port_mode[p]),
            .phys_tag (port_tag[p])
        );
    end

    assign ra_tag  = port_tag[0];
    assign rb_tag  = port_tag[1];
    assign wc_tag  = port_tag[2];
    assign bank_we = wr_en && (wc_idx != IDX_W'(ZERO_IDX));

    shreg_bank #(
        .DATA_W  (DATA_W),
        .NUM_PHYS(NUM_PHYS),
        .TAG_W   (TAG_W),
        .ZERO_TAG(ZERO_IDX),
        .NUM_RD  (NUM_RD)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bank_we),
        .wtag   (port_tag[2]),
        .wdata  (wc_data),
        .rd_tag ({port_tag[1], port_tag[0]}),
        .rd_data(rd_data)
    );

    assign ra_data = rd_data[0];
    assign rb_data = rd_data[1];

    // R1: tags stay inside the physical file
    assert_tag_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ra_tag < TAG_W'(NUM_PHYS) && rb_tag < TAG_W'(NUM_PHYS) && wc_tag < TAG_W'(NUM_PHYS));
    // R2: mode 0 keeps the index as the tag
    assert_plain_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ra_mode |-> ra_tag == TAG_W'(ra_idx));
    // R3: a steered index in mode 1 lands in the shadow bank
    assert_shadow_steer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wc_mode && REDIR_MASK[wc_idx]) |-> wc_tag >= TAG_W'(ARCH_REGS));
    // R4: both read ports agree for the same index and mode
    assert_ports_agree_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_idx == rb_idx && ra_mode == rb_mode) |-> (ra_tag == rb_tag && ra_data == rb_data));
    // R5: the zero register reads zero in both modes
    assert_zero_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_idx == IDX_W'(ZERO_IDX)) |-> rb_data == '0);
    // R6: a committed write is visible on port A from the next cycle
    assert_wr_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wc_idx != IDX_W'(ZERO_IDX)) |=>
        (ra_tag != $past(wc_tag) || ra_data == $past(wc_data)));

endmodule

// File: tb/shreg_rf_top_tb_top.sv
`timescale 1ns/1ps
module shreg_rf_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ra_idx = '0, rb_idx = '0, wc_idx = '0;
    logic        ra_mode = 1'b0, rb_mode = 1'b0, wc_mode = 1'b0, wr_en = 1'b0;
    logic [63:0] wc_data = '0;
    logic [63:0] ra_data, rb_data;
    logic [5:0]  ra_tag, rb_tag, wc_tag;

    int total = 0;
    int bad   = 0;

    logic [63:0] norm_m [32];
    logic [63:0] shad_m [32];

    always #2.5 clk = ~clk;

    shreg_rf_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(ra_idx), .ra_mode(ra_mode), .ra_data(ra_data), .ra_tag(ra_tag),
        .rb_idx(rb_idx), .rb_mode(rb_mode), .rb_data(rb_data), .rb_tag(rb_tag),
        .wr_en(wr_en), .wc_idx(wc_idx), .wc_mode(wc_mode), .wc_data(wc_data),
        .wc_tag(wc_tag)
    );

    function automatic int exp_tag(input int idx, input bit m);
        if (!m) return idx;
        if (idx >= 8 && idx <= 14) return idx + 24;
        if (idx == 25) return 39;
        return idx;
    endfunction

    function automatic logic [63:0] exp_data(input int idx, input bit m);
        if (idx == 31) return 64'd0;
        if (exp_tag(idx, m) >= 32) return shad_m[idx];
        return norm_m[idx];
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare, then commit at the rising edge
    task automatic step(input string req,
                        input int a, input bit am, input int b, input bit bm,
                        input bit we, input int c, input bit cm, input logic [63:0] d);
        @(negedge clk);
        ra_idx = 5'(a); ra_mode = am; rb_idx = 5'(b); rb_mode = bm;
        wr_en = we; wc_idx = 5'(c); wc_mode = cm; wc_data = d;
        #1;
        chk(req, "ra_data", ra_data, exp_data(a, am));
        chk(req, "rb_data", rb_data, exp_data(b, bm));
        chk(req, "ra_tag", 64'(ra_tag), 64'(exp_tag(a, am)));
        chk(req, "rb_tag", 64'(rb_tag), 64'(exp_tag(b, bm)));
        chk(req, "wc_tag", 64'(wc_tag), 64'(exp_tag(c, cm)));
        @(posedge clk);
        #0.1;
        if (we && c != 31) begin
            if (exp_tag(c, cm) >= 32) shad_m[c] = d;
            else norm_m[c] = d;
        end
    endtask

    initial begin
        #500000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            norm_m[i] = '0;
            shad_m[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: everything reads zero after reset, both modes
        for (int i = 0; i < 32; i++) step("R8", i, 1'b0, i, 1'b1, 1'b0, i, 1'b1, 64'd0);

        // R2 / R6: fill the normal bank in mode 0
        for (int i = 0; i < 32; i++)
            step("R2", i, 1'b0, (i + 31) % 32, 1'b0, 1'b1, i, 1'b0, {32'hA5A5_0000, 32'(i)});

        // R3: fill steered indices through mode 1
        for (int i = 8; i <= 14; i++)
            step("R3", i, 1'b1, i, 1'b0, 1'b1, i, 1'b1, {32'h5A5A_1111, 32'(i)});
        step("R3", 25, 1'b1, 25, 1'b0, 1'b1, 25, 1'b1, 64'hDEAD_BEEF_0000_0019);

        // R10: both banks keep their own values, read in both modes
        for (int i = 0; i < 32; i++) step("R10", i, 1'b1, i, 1'b0, 1'b0, 0, 1'b0, 64'd0);

        // R4: unsteered index written in mode 1 reaches the normal bank; ports steer independently
        step("R4", 3, 1'b1, 9, 1'b0, 1'b1, 3, 1'b1, 64'h0303_0303_0303_0303);
        step("R4", 3, 1'b0, 9, 1'b1, 1'b1, 9, 1'b0, 64'h0909_0909_0909_0909);
        step("R4", 9, 1'b1, 9, 1'b0, 1'b0, 0, 1'b0, 64'd0);

        // R5: writes to index 31 are dropped in both modes
        step("R5", 31, 1'b0, 31, 1'b1, 1'b1, 31, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        step("R5", 31, 1'b1, 31, 1'b0, 1'b1, 31, 1'b1, 64'hFFFF_0000_FFFF_0000);
        step("R5", 31, 1'b0, 31, 1'b1, 1'b0, 0, 1'b0, 64'd0);

        // R7: read the register that is being written this cycle
        step("R7", 5, 1'b0, 12, 1'b1, 1'b1, 5, 1'b0, 64'h7777_0000_0000_0005);
        step("R7", 12, 1'b1, 5, 1'b0, 1'b1, 12, 1'b1, 64'h7777_0000_0000_000C);
        step("R7", 5, 1'b0, 12, 1'b1, 1'b0, 0, 1'b0, 64'd0);

        // R9: write data present with enable low changes nothing
        step("R9", 20, 1'b0, 13, 1'b1, 1'b0, 20, 1'b0, 64'h9999_9999_9999_9999);
        step("R9", 20, 1'b0, 13, 1'b1, 1'b0, 13, 1'b1, 64'h8888_8888_8888_8888);
        step("R9", 20, 1'b0, 13, 1'b1, 1'b0, 0, 1'b0, 64'd0);

        // R1: random mixed-mode traffic
        for (int n = 0; n < 600; n++)
            step("R1", int'($urandom_range(31)), 1'($urandom), int'($urandom_range(31)), 1'($urandom),
                 1'($urandom), int'($urandom_range(31)), 1'($urandom), {$urandom, $urandom});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule